// File: doc/BRIEF.md
# Fast Ethernet Transmit Line-Symbol Encoder

This block turns the nibble-wide transmit stream of a 100 Mb/s media access controller into the serial, three-level line code used on twisted-pair copper. It runs on a single bit-rate clock and divides it by five internally. It raises a one-cycle load strobe in the cycle where the caller must present the next transmit nibble and enable. Outside a frame it sends the all-ones Idle code group. When enable first rises, the first two preamble nibbles are replaced by the two start-delimiter code groups. The following nibbles are converted with the standard four-to-five-bit code. When enable falls, two end-delimiter code groups are sent and the encoder returns to Idle.

Each five-bit code group is shifted out most significant bit first. The serial stream then passes either straight through or through a one-stage registered slot reserved for a scrambler, depending on a mode input. A three-level encoder steps the line level on every serial one and holds it on every serial zero.

Top module: `fx_tx_line_encoder`

## Requirements
- R1: After reset `ser_bit` is 0, `line_lvl` is 2'b00 and `nib_ld` is 0 until the first load cycle.
- R2: `nib_ld` is high for exactly one cycle in every five; `tx_en` and `txd` are captured at the rising edge that ends that cycle.
- R3: A load with `tx_en`=1 while idle emits start code group 5'b11000; the next load emits 5'b10001 whatever `txd` and `tx_en` hold.
- R4: Inside a frame, each load with `tx_en`=1 emits the four-to-five-bit code for `txd` (0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101).
- R5: The first load inside a frame with `tx_en`=0 emits 5'b01101, whatever `txd` holds. The next load emits 5'b00111 and the frame ends.
- R6: Outside a frame, each load with `tx_en`=0 emits the Idle code group 5'b11111.
- R7: With `scr_bypass`=1, bit 4 of a code group appears on `ser_bit` in the cycle after its load edge, and bits 3 to 0 follow on the four cycles after that.
- R8: With `scr_bypass`=0, `ser_bit` carries the same sequence one cycle later than in bypass mode.
- R9: `line_lvl` moves one step in the cyclic order 0, +1, 0, -1 on the edge after a cycle where `ser_bit` is 1, and holds after a cycle where it is 0.
- R10: The level code is 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. Reset leaves the level at 0 with the next step going to +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scr_bypass | input | 1 | 1 sends code-group bits directly; 0 routes them through the scrambler slot |
| tx_en | input | 1 | Transmit enable from the controller |
| txd | input | 4 | Transmit nibble |
| nib_ld | output | 1 | Cycle in which `tx_en`/`txd` are taken |
| ser_bit | output | 1 | Serial code-group bit stream |
| line_lvl | output | 2 | Three-level line state, signed code |

## Verification
The bench uses the default widths: a four-bit nibble and a five-bit code group. With these, a single frame carries all sixteen nibble values, and the one-in-five load cadence is visible cycle by cycle. Two frames are sent back to back, and the second frame puts non-preamble data in the second-delimiter slot. The whole sequence runs once in each path mode, so the single-bit delay of the scrambler slot is checked against the bypass timing.

// File: rtl/fx_tx_pkg.sv
package fx_tx_pkg;

    localparam int NIB_W = 4;
    localparam int SYM_W = 5;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SSD_K = 2'd1,
        FR_DATA  = 2'd2,
        FR_ESD_R = 2'd3
    } fr_state_e;

    localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
    localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
    localparam logic [SYM_W-1:0] CG_R    = 5'b00111;

    localparam logic [1:0] LVL_ZERO = 2'b00;
    localparam logic [1:0] LVL_POS  = 2'b01;
    localparam logic [1:0] LVL_NEG  = 2'b11;

    function automatic logic [SYM_W-1:0] nib_to_cg(input logic [NIB_W-1:0] n);
        logic [SYM_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fx_frame_ctl.sv
module fx_frame_ctl
    import fx_tx_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int SW = SYM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          tx_en,
    input  logic [NW-1:0] txd,
    output logic [SW-1:0] cg
);

    typedef struct packed {
        fr_state_e st;
    } fr_regs_t;

    fr_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        cg    = CG_IDLE;
        case (cur_q.st)
            FR_IDLE: begin
                if (tx_en) begin
                    cg = CG_J;
                    if (ld) nxt_d.st = FR_SSD_K;
                end
            end
            FR_SSD_K: begin
                cg = CG_K;
                if (ld) nxt_d.st = FR_DATA;
            end
            FR_DATA: begin
                if (tx_en) begin
                    cg = nib_to_cg(txd);
                end else begin
                    cg = CG_T;
                    if (ld) nxt_d.st = FR_ESD_R;
                end
            end
            default: begin
                cg = CG_R;
                if (ld) nxt_d.st = FR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: FR_IDLE};
        else        cur_q <= nxt_d;
    end

    // R3: a start in idle is always followed by the second start code group
    a_r3_k_follows_j : assert property (@(posedge clk) disable iff (!rst_n)
        (ld && cur_q.st == FR_IDLE && tx_en) |=> (cur_q.st == FR_SSD_K));

    // R5: end of frame goes to the second end code group
    a_r5_r_follows_t : assert property (@(posedge clk) disable iff (!rst_n)
        (ld && cur_q.st == FR_DATA && !tx_en) |=> (cur_q.st == FR_ESD_R));

    // R5: second end code group returns to idle
    a_r5_back_to_idle : assert property (@(posedge clk) disable iff (!rst_n)
        (ld && cur_q.st == FR_ESD_R) |=> (cur_q.st == FR_IDLE));

    // R2: state never moves outside a load cycle
    a_r2_state_on_ld : assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(cur_q.st));

endmodule

// File: rtl/fx_sym_shifter.sv
module fx_sym_shifter
    import fx_tx_pkg::*;
#(
    parameter int SW = SYM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] cg,
    output logic          ld,
    output logic          bit_out
);

    localparam int CW = (SW > 1) ? $clog2(SW) : 1;
    localparam logic [CW-1:0] LAST = CW'(SW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [SW-1:0] sr;
    } sh_regs_t;

    sh_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        ld    = (cur_q.cnt == LAST);
        if (ld) begin
            nxt_d.cnt = '0;
            nxt_d.sr  = cg;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
            nxt_d.sr  = {cur_q.sr[SW-2:0], 1'b0};
        end
        bit_out = cur_q.sr[SW-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{cnt: '0, sr: '0};
        else        cur_q <= nxt_d;
    end

    // R2: the load strobe never lasts two cycles
    a_r2_ld_single : assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> !ld);

    // R7: the loaded group's top bit is presented right after the load
    a_r7_msb_first : assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (bit_out == $past(cg[SW-1])));

endmodule

// File: rtl/fx_scr_slot.sv
module fx_scr_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic bit_in,
    output logic bit_out
);

    typedef struct packed {
        logic b;
    } sc_regs_t;

    sc_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d.b = bit_in;
        bit_out = bypass ? bit_in : cur_q.b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{b: 1'b0};
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/fx_mlt3_line.sv
module fx_mlt3_line
    import fx_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_in,
    output logic [1:0] lvl
);

    typedef struct packed {
        logic [1:0] ph;
    } ml_regs_t;

    ml_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (bit_in) nxt_d.ph = cur_q.ph + 2'd1;
        case (cur_q.ph)
            2'd1:    lvl = LVL_POS;
            2'd3:    lvl = LVL_NEG;
            default: lvl = LVL_ZERO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{ph: 2'd0};
        else        cur_q <= nxt_d;
    end

    // R9: a zero bit holds the level
    a_r9_hold_on_zero : assert property (@(posedge clk) disable iff (!rst_n)
        !bit_in |=> $stable(lvl));

    // R9: a one bit changes the level
    a_r9_move_on_one : assert property (@(posedge clk) disable iff (!rst_n)
        bit_in |=> (lvl != $past(lvl)));

    // R9: from either extreme the next step is back to zero
    a_r9_extreme_to_zero : assert property (@(posedge clk) disable iff (!rst_n)
        (bit_in && lvl != LVL_ZERO) |=> (lvl == LVL_ZERO));

    // R10: only the three legal level codes appear
    a_r10_legal_code : assert property (@(posedge clk) disable iff (!rst_n)
        lvl != 2'b10);

endmodule

// File: rtl/fx_tx_line_encoder.sv
module fx_tx_line_encoder
    import fx_tx_pkg::*;
#(
    parameter int NW = NIB_W,
    parameter int SW = SYM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scr_bypass,
    input  logic          tx_en,
    input  logic [NW-1:0] txd,
    output logic          nib_ld,
    output logic          ser_bit,
    output logic [1:0]    line_lvl
);

    logic [SW-1:0] cg_w;
    logic          ld_w;
    logic          raw_bit_w;

    fx_frame_ctl #(.NW(NW), .SW(SW)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_w),
        .tx_en (tx_en),
        .txd   (txd),
        .cg    (cg_w)
    );

    fx_sym_shifter #(.SW(SW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cg      (cg_w),
        .ld      (ld_w),
        .bit_out (raw_bit_w)
    );

    fx_scr_slot u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bypass  (scr_bypass),
        .bit_in  (raw_bit_w),
        .bit_out (ser_bit)
    );

    fx_mlt3_line u_mlt (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (ser_bit),
        .lvl    (line_lvl)
    );

    assign nib_ld = ld_w;

    // R8: in the scrambler path the line bit trails the shifter by one cycle
    a_r8_slot_delay : assert property (@(posedge clk) disable iff (!rst_n)
        (!scr_bypass && $past(!scr_bypass)) |-> (ser_bit == $past(raw_bit_w)));

endmodule

// File: tb/fx_tx_line_encoder_tb_top.sv
`timescale 1ns/1ps
module fx_tx_line_encoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scr_bypass = 1'b1;
    logic       tx_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       nib_ld;
    logic       ser_bit;
    logic [1:0] line_lvl;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fx_tx_line_encoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scr_bypass (scr_bypass),
        .tx_en      (tx_en),
        .txd        (txd),
        .nib_ld     (nib_ld),
        .ser_bit    (ser_bit),
        .line_lvl   (line_lvl)
    );

    // vector: {req[3:0], en, txd[3:0], code group[4:0]}
    localparam int NV = 35;
    localparam logic [13:0] VEC [NV] = '{
        {4'd6, 1'b0, 4'h0, 5'b11111},
        {4'd6, 1'b0, 4'h3, 5'b11111},
        {4'd3, 1'b1, 4'h5, 5'b11000},
        {4'd3, 1'b1, 4'h5, 5'b10001},
        {4'd4, 1'b1, 4'h5, 5'b01011},
        {4'd4, 1'b1, 4'hD, 5'b11011},
        {4'd4, 1'b1, 4'h0, 5'b11110},
        {4'd4, 1'b1, 4'h1, 5'b01001},
        {4'd4, 1'b1, 4'h2, 5'b10100},
        {4'd4, 1'b1, 4'h3, 5'b10101},
        {4'd4, 1'b1, 4'h4, 5'b01010},
        {4'd4, 1'b1, 4'h5, 5'b01011},
        {4'd4, 1'b1, 4'h6, 5'b01110},
        {4'd4, 1'b1, 4'h7, 5'b01111},
        {4'd4, 1'b1, 4'h8, 5'b10010},
        {4'd4, 1'b1, 4'h9, 5'b10011},
        {4'd4, 1'b1, 4'hA, 5'b10110},
        {4'd4, 1'b1, 4'hB, 5'b10111},
        {4'd4, 1'b1, 4'hC, 5'b11010},
        {4'd4, 1'b1, 4'hD, 5'b11011},
        {4'd4, 1'b1, 4'hE, 5'b11100},
        {4'd4, 1'b1, 4'hF, 5'b11101},
        {4'd5, 1'b0, 4'h7, 5'b01101},
        {4'd5, 1'b0, 4'h0, 5'b00111},
        {4'd3, 1'b1, 4'h5, 5'b11000},
        {4'd3, 1'b1, 4'hA, 5'b10001},
        {4'd4, 1'b1, 4'hD, 5'b11011},
        {4'd4, 1'b1, 4'h0, 5'b11110},
        {4'd5, 1'b0, 4'hF, 5'b01101},
        {4'd5, 1'b1, 4'h9, 5'b00111},
        {4'd6, 1'b0, 4'h9, 5'b11111},
        {4'd6, 1'b0, 4'h0, 5'b11111},
        {4'd3, 1'b1, 4'h5, 5'b11000},
        {4'd5, 1'b0, 4'h5, 5'b10001},
        {4'd5, 1'b0, 4'h2, 5'b01101}
    };

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [1:0] lvl_of(input int ph);
        case (ph % 4)
            1:       return 2'b01;
            3:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic byp);
        rst_n      = 1'b0;
        scr_bypass = byp;
        tx_en      = 1'b0;
        txd        = 4'h0;
        repeat (3) @(negedge clk);
        check(ser_bit == 1'b0, "R1", "ser_bit in reset", ser_bit, 0);
        check(line_lvl == 2'b00, "R10", "level in reset", line_lvl, 0);
        check(nib_ld == 1'b0, "R1", "nib_ld in reset", nib_ld, 0);
        rst_n = 1'b1;
    endtask

    task automatic run_table(input logic byp);
        int   ph = 0;
        logic prev_bit = 1'b0;
        string tser;
        while (!nib_ld) begin
            check(ser_bit == 1'b0, "R1", "ser_bit before first load", ser_bit, 0);
            check(line_lvl == 2'b00, "R1", "level before first load", line_lvl, 0);
            @(negedge clk);
        end
        for (int v = 0; v < NV; v++) begin
            logic [4:0] cg = VEC[v][4:0];
            tx_en = VEC[v][9];
            txd   = VEC[v][8:5];
            tser  = byp ? tag_of(VEC[v][13:10]) : "R8";
            for (int k = 0; k < 5; k++) begin
                logic eb;
                @(negedge clk);
                if (byp) eb = cg[4-k];
                else     eb = (k == 0) ? prev_bit : cg[5-k];
                check(ser_bit == eb, tser, $sformatf("vec %0d bit %0d (R7 order)", v, k),
                      ser_bit, eb);
                check(line_lvl == lvl_of(ph), "R9", $sformatf("level vec %0d bit %0d", v, k),
                      line_lvl, lvl_of(ph));
                check(nib_ld == (k == 4), "R2", $sformatf("load strobe vec %0d cycle %0d", v, k),
                      nib_ld, (k == 4));
                if (eb) ph++;
            end
            prev_bit = cg[0];
        end
        tx_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        run_table(1'b1);
        do_reset(1'b0);
        run_table(1'b0);
        // R10: first one bit after reset moves the level to +1
        do_reset(1'b1);
        tx_en = 1'b0;
        while (!nib_ld) @(negedge clk);
        @(negedge clk);
        check(ser_bit == 1'b1, "R6", "idle first bit", ser_bit, 1);
        @(negedge clk);
        check(line_lvl == 2'b01, "R10", "first step goes to +1", line_lvl, 1);
        @(negedge clk);
        check(line_lvl == 2'b00, "R10", "second step back to 0", line_lvl, 0);
        @(negedge clk);
        check(line_lvl == 2'b11, "R10", "third step goes to -1", line_lvl, 3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule